// File: doc/BRIEF.md
# Rotating History Address Sequencer for Subband Synthesis

This block drives the address and control side of the last stage of a subband audio synthesis filter. A single buffer of 512 words holds sixteen blocks of history. Each block has 32 values from the cosine matrixing stage. The same buffer then feeds the windowing multiply-accumulate. The block never moves data to age the history. It keeps a base offset instead, and every new block moves that offset back by one block, wrapping modulo the buffer depth. The newest block is always found at the base offset, and older blocks follow it at steps of 32 words.

Use is strobe-driven. A new-block strobe opens a write phase. Each matrixing result that arrives with a valid strobe gets the next write address. After the 32nd write, the block runs 512 windowing terms with no gaps, one per clock. Each term gives a history read address, a coefficient ROM address, and clear, accumulate and negate controls for an external MAC. Every sixteenth term completes one PCM sample. Only half of each 64-value vector is stored, so odd history blocks are read at the mirrored index with negation. History blocks that were never written since reset are kept out of the sum, so the first outputs are silent.

Top module: `pwin_addr_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it, buf_we, mac_clr, mac_acc, mac_neg, pcm_valid and slot_done are low, and buf_addr and rom_addr are zero. The base offset restarts at zero and the count of filled history blocks restarts at zero.
- R2: When idle, a blk_new strobe lowers the base offset by 32 modulo 512 and opens a write phase. The n-th mtx_valid seen in that phase (n = 0..31) gives buf_we high for one cycle, one cycle later, with buf_addr = (base + n) mod 512.
- R3: mtx_valid is ignored outside a write phase: buf_we stays low.
- R4: The clock after the 32nd write, 512 windowing terms follow on consecutive cycles. They run output index j = 0..31 as the outer loop and history block m = 0..15 as the inner loop, and buf_we stays low throughout.
- R5: For term (j, m), buf_addr = (base + 32·m + idx) mod 512, where idx = j for even m and 31 − j for odd m. mac_neg is high exactly for odd m.
- R6: For term (j, m), rom_addr = j + 32·m.
- R7: mac_clr is high on term m = 0 and on no other term. It means the MAC loads the product instead of adding it.
- R8: mac_acc is high for term (j, m) only when m is less than the number of blocks received since reset, counting the current block and saturating at 16.
- R9: pcm_valid pulses for one cycle, one cycle after each m = 15 term, giving 32 pulses per block. slot_done pulses together with the 32nd pulse.
- R10: blk_new is ignored during the write phase and during windowing. The base offset moves only once per accepted block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_new | input | 1 | Start of a new matrixing block |
| mtx_valid | input | 1 | One matrixing result is ready to be written |
| buf_addr | output | 9 | History buffer address (write or read) |
| buf_we | output | 1 | History buffer write enable |
| rom_addr | output | 9 | Window coefficient ROM address |
| mac_clr | output | 1 | MAC loads this product and discards the old sum |
| mac_acc | output | 1 | MAC uses this product (low: skip the term) |
| mac_neg | output | 1 | MAC negates the buffer value for this term |
| pcm_valid | output | 1 | The MAC holds a finished PCM sample |
| slot_done | output | 1 | Last PCM sample of the block |

## Verification
The bench sends seventeen blocks. The base offset passes through zero and wraps, and the fill count goes from one up to saturation. A design that wrapped wrongly or let the fill count run past 16 would read the wrong history or mute live blocks. Matrixing valids arrive with gaps, and stray valids come while idle and during windowing. A design that wrote on those would corrupt the history. A blk_new pulse in the middle of windowing must leave the next block's write addresses exactly one block step further on. Every term is compared on mirrored index, sign, coefficient address and clear position, so a mirror applied to even blocks or a clear placed on the wrong term shows up at once.

// File: rtl/pwin_pkg.sv
package pwin_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WRITE = 2'd1,
    PH_WIN   = 2'd2
  } phase_t;
endpackage

// File: rtl/pwin_ring.sv
// Rotating base offset and saturating count of filled history blocks.
module pwin_ring #(
  parameter int NSUB  = 32,
  parameter int NHIST = 16,
  localparam int DEPTH = NSUB * NHIST,
  localparam int AW    = $clog2(DEPTH),
  localparam int FW    = $clog2(NHIST + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [AW-1:0] base,
  output logic [FW-1:0] fill
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base <= '0;
      fill <= '0;
    end else if (adv) begin
      base <= base - AW'(NSUB);
      if (fill != FW'(NHIST)) fill <= fill + 1'b1;
    end
  end
endmodule

// File: rtl/pwin_seq.sv
// Phase control: write phase counter, then j-outer / m-inner term loop.
module pwin_seq
  import pwin_pkg::*;
#(
  parameter int NSUB  = 32,
  parameter int NHIST = 16,
  localparam int SW = $clog2(NSUB),
  localparam int HW = $clog2(NHIST)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          blk_new,
  input  logic          mtx_valid,
  output logic          adv,
  output logic          wr_fire,
  output logic [SW-1:0] wcnt,
  output logic          term_fire,
  output logic [SW-1:0] j,
  output logic [HW-1:0] m,
  output logic          term_last,
  output logic          slot_last
);
  phase_t phase;

  assign adv       = (phase == PH_IDLE) && blk_new;
  assign wr_fire   = (phase == PH_WRITE) && mtx_valid;
  assign term_fire = (phase == PH_WIN);
  assign term_last = (m == HW'(NHIST - 1));
  assign slot_last = term_last && (j == SW'(NSUB - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      wcnt  <= '0;
      j     <= '0;
      m     <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (blk_new) begin
            phase <= PH_WRITE;
            wcnt  <= '0;
          end
        end
        PH_WRITE: begin
          if (mtx_valid) begin
            wcnt <= wcnt + 1'b1;
            if (wcnt == SW'(NSUB - 1)) begin
              phase <= PH_WIN;
              j     <= '0;
              m     <= '0;
            end
          end
        end
        PH_WIN: begin
          if (term_last) begin
            m <= '0;
            j <= j + 1'b1;
            if (slot_last) phase <= PH_IDLE;
          end else begin
            m <= m + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pwin_addr_gen.sv
// Top: registered buffer / ROM addresses and MAC controls.
module pwin_addr_gen #(
  parameter int NSUB  = 32,
  parameter int NHIST = 16,
  localparam int DEPTH = NSUB * NHIST,
  localparam int AW    = $clog2(DEPTH),
  localparam int SW    = $clog2(NSUB),
  localparam int HW    = $clog2(NHIST),
  localparam int FW    = $clog2(NHIST + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          blk_new,
  input  logic          mtx_valid,
  output logic [AW-1:0] buf_addr,
  output logic          buf_we,
  output logic [AW-1:0] rom_addr,
  output logic          mac_clr,
  output logic          mac_acc,
  output logic          mac_neg,
  output logic          pcm_valid,
  output logic          slot_done
);
  logic [AW-1:0] base;
  logic [FW-1:0] fill;
  logic          adv, wr_fire, term_fire, term_last, slot_last;
  logic [SW-1:0] wcnt, j, idx;
  logic [HW-1:0] m;
  logic [AW-1:0] blk_off;
  logic          last_q, slot_q;

  pwin_ring #(.NSUB(NSUB), .NHIST(NHIST)) u_ring (
    .clk(clk), .rst(rst), .adv(adv), .base(base), .fill(fill)
  );

  pwin_seq #(.NSUB(NSUB), .NHIST(NHIST)) u_seq (
    .clk(clk), .rst(rst), .blk_new(blk_new), .mtx_valid(mtx_valid),
    .adv(adv), .wr_fire(wr_fire), .wcnt(wcnt), .term_fire(term_fire),
    .j(j), .m(m), .term_last(term_last), .slot_last(slot_last)
  );

  // Odd history blocks supply the mirrored half of the 64-value vector.
  assign idx     = m[0] ? (SW'(NSUB - 1) - j) : j;
  assign blk_off = AW'(m) * AW'(NSUB);

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_addr  <= '0;
      buf_we    <= 1'b0;
      rom_addr  <= '0;
      mac_clr   <= 1'b0;
      mac_acc   <= 1'b0;
      mac_neg   <= 1'b0;
      last_q    <= 1'b0;
      slot_q    <= 1'b0;
      pcm_valid <= 1'b0;
      slot_done <= 1'b0;
    end else begin
      buf_we    <= wr_fire;
      mac_clr   <= term_fire && (m == '0);
      mac_acc   <= term_fire && (FW'(m) < fill);
      mac_neg   <= term_fire && m[0];
      last_q    <= term_fire && term_last;
      slot_q    <= term_fire && slot_last;
      pcm_valid <= last_q;
      slot_done <= slot_q;
      if (wr_fire) begin
        buf_addr <= base + AW'(wcnt);
      end else if (term_fire) begin
        buf_addr <= base + blk_off + AW'(idx);
        rom_addr <= AW'(j) + blk_off;
      end
    end
  end
endmodule

// File: rtl/pwin_addr_gen_chk.sv
module pwin_addr_gen_chk #(
  parameter int AW = 9,
  parameter int SW = 5,
  parameter int NSUB = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] buf_addr,
  input logic          buf_we,
  input logic [AW-1:0] rom_addr,
  input logic          mac_clr,
  input logic          mac_acc,
  input logic          mac_neg,
  input logic          pcm_valid,
  input logic          slot_done
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !buf_we && !pcm_valid && !slot_done && !mac_acc);  // R1
  AST_WRITE_STEP: assert property (@(posedge clk) disable iff (rst)
    (buf_we && $past(buf_we)) |-> buf_addr == AW'($past(buf_addr) + 1'b1));  // R2
  AST_WE_NOT_TERM: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> !mac_acc && !mac_clr && !mac_neg);  // R3
  AST_NEG_ODD_BLOCK: assert property (@(posedge clk) disable iff (rst)
    mac_neg |-> rom_addr[SW]);  // R5
  AST_CLR_FIRST_BLOCK: assert property (@(posedge clk) disable iff (rst)
    mac_clr |-> rom_addr < AW'(NSUB));  // R7
  AST_PCM_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pcm_valid |=> !pcm_valid);  // R9
  AST_DONE_WITH_PCM: assert property (@(posedge clk) disable iff (rst)
    slot_done |-> pcm_valid);  // R9
endmodule

bind pwin_addr_gen pwin_addr_gen_chk #(.AW(AW), .SW(SW), .NSUB(NSUB)) u_chk (
  .clk(clk), .rst(rst), .buf_addr(buf_addr), .buf_we(buf_we),
  .rom_addr(rom_addr), .mac_clr(mac_clr), .mac_acc(mac_acc),
  .mac_neg(mac_neg), .pcm_valid(pcm_valid), .slot_done(slot_done)
);

// File: tb/sim_pwin_addr_gen.sv
`timescale 1ns/1ps
module sim_pwin_addr_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic blk_new = 1'b0;
  logic mtx_valid = 1'b0;
  logic [8:0] buf_addr, rom_addr;
  logic buf_we, mac_clr, mac_acc, mac_neg, pcm_valid, slot_done;

  int n_run = 0;
  int n_fail = 0;
  int base_m = 0;
  int fill_m = 0;

  always #10 clk = ~clk;

  pwin_addr_gen u0 (
    .clk(clk), .rst(rst), .blk_new(blk_new), .mtx_valid(mtx_valid),
    .buf_addr(buf_addr), .buf_we(buf_we), .rom_addr(rom_addr),
    .mac_clr(mac_clr), .mac_acc(mac_acc), .mac_neg(mac_neg),
    .pcm_valid(pcm_valid), .slot_done(slot_done)
  );

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // R1: reset state
  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 buf_we", buf_we, 0);
    check("R1 buf_addr", buf_addr, 0);
    check("R1 rom_addr", rom_addr, 0);
    check("R1 mac_clr", mac_clr, 0);
    check("R1 mac_acc", mac_acc, 0);
    check("R1 mac_neg", mac_neg, 0);
    check("R1 pcm_valid", pcm_valid, 0);
    check("R1 slot_done", slot_done, 0);
    base_m = 0;
    fill_m = 0;
  endtask

  // R3: stray valids while idle
  task automatic test_idle_valid();
    for (int c = 0; c < 4; c++) begin
      mtx_valid = 1'b1;
      @(negedge clk);
      check("R3 idle buf_we", buf_we, 0);
    end
    mtx_valid = 1'b0;
  endtask

  // R2 R4-R10: one whole block; gaps in valids, optional stray pulses in window
  task automatic run_block(bit gaps, bit stray);
    int cnt;
    bit v;
    base_m = (base_m - 32) & 511;
    if (fill_m < 16) fill_m++;
    blk_new = 1'b1;
    @(negedge clk);
    blk_new = 1'b0;
    cnt = 0;
    v = 1'b1;
    while (cnt < 32) begin
      mtx_valid = v;
      @(negedge clk);
      if (v) begin
        check("R2 write we", buf_we, 1);
        check("R2 write addr", buf_addr, (base_m + cnt) & 511);
        cnt++;
      end else begin
        check("R3 gap no write", buf_we, 0);
      end
      blk_new = (cnt == 5);  // R10: ignored in write phase
      v = gaps ? ~v : 1'b1;
    end
    mtx_valid = 1'b0;
    blk_new = 1'b0;
    for (int k = 0; k < 512; k++) begin
      int jj, mm, ix;
      jj = k / 16;
      mm = k % 16;
      ix = (mm % 2 == 1) ? 31 - jj : jj;
      if (stray && (k == 100 || k == 101)) begin
        blk_new = 1'b1;
        mtx_valid = 1'b1;
      end else begin
        blk_new = 1'b0;
        mtx_valid = 1'b0;
      end
      @(negedge clk);
      check("R4 no write in window", buf_we, 0);
      check("R5 read addr", buf_addr, (base_m + 32 * mm + ix) & 511);
      check("R5 neg", mac_neg, mm % 2);
      check("R6 rom addr", rom_addr, jj + 32 * mm);
      check("R7 clr", mac_clr, (mm == 0) ? 1 : 0);
      check("R8 acc", mac_acc, (mm < fill_m) ? 1 : 0);
      check("R9 pcm", pcm_valid, (k >= 1 && (k - 1) % 16 == 15) ? 1 : 0);
      check("R9 done early", slot_done, 0);
    end
    blk_new = 1'b0;
    mtx_valid = 1'b0;
    @(negedge clk);
    check("R9 last pcm", pcm_valid, 1);
    check("R9 slot_done", slot_done, 1);
    @(negedge clk);
    check("R9 pcm single", pcm_valid, 0);
    check("R9 done single", slot_done, 0);
  endtask

  initial begin
    test_reset();
    test_idle_valid();
    run_block(1'b0, 1'b0);
    test_idle_valid();
    run_block(1'b1, 1'b0);
    for (int b = 3; b <= 17; b++)
      run_block(b[0], b == 5);  // R10 stray blk_new during window at block 5
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule